// File: doc/BRIEF.md
# Transparent Clock Residence Correction

This block lives in the forwarding path of a two-port bridge that acts as a transparent clock for a precision time protocol. When a timing message enters the bridge, an ingress event gives its timestamp, its message type and a small tag. The tag follows the message through the bridge. When the message leaves, an egress event gives the same tag, the egress timestamp and the correction value carried by the message. The block measures how long the message stayed in the bridge and returns the correction value that the frame must carry on the wire.

Only the two event message types, Sync and delay request, have their residence time added. Follow-up, delay response and every other type go out with the correction they came in with. This is how the delay response can bring the sum of corrections back to the slave. Each tag has one slot in a table, so several messages can be in flight at the same time and leave in any order. An egress event whose tag has no open slot is reported as an error, and its correction passes through unchanged.

Top module: `tc_residence_corr`

## Requirements
- R1: After reset, out_valid and out_err are low and no tag slot is open. An egress event on any tag before any ingress event is therefore reported as a miss.
- R2: For an egress that matches an ingress of type 4'h0 (Sync), out_corr = egr_corr + (residence << 16). The residence is (egr_ts - ing_ts) modulo 2^TS_W, zero-extended.
- R3: For an egress that matches an ingress of type 4'h1 (delay request), the same residence correction as in R2 is added.
- R4: For an egress that matches an ingress of any other type (4'h8 follow-up, 4'h9 delay response, and all others), out_corr equals egr_corr, with out_err low.
- R5: An egress whose tag has no open slot gives out_corr equal to egr_corr and out_err high.
- R6: When egr_ts is less than the stored ing_ts, the residence wraps modulo 2^TS_W before it is scaled and added.
- R7: out_valid is high exactly in the cycle after each cycle with egr_valid high, and low otherwise. out_corr and out_err are meaningful while out_valid is high.
- R8: An egress event closes the slot of its tag. A second egress on that tag with no new ingress is a miss.
- R9: When an ingress and an egress with the same tag arrive in the same cycle, the egress uses the entry stored before that cycle, and the new ingress stays open for a later egress.
- R10: Up to 2^TAG_W messages with distinct tags can be in flight at once and can leave in any order. Each one gets its own residence time.
- R11: The correction is a signed two's complement value of CORR_W bits. Negative corrections are handled, and the sum wraps modulo 2^CORR_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ing_valid | input | 1 | Ingress event strobe |
| ing_tag | input | TAG_W | Tag of the message entering |
| ing_ts | input | TS_W | Ingress timestamp in ns |
| ing_type | input | 4 | Message type of the entering message |
| egr_valid | input | 1 | Egress event strobe |
| egr_tag | input | TAG_W | Tag of the message leaving |
| egr_ts | input | TS_W | Egress timestamp in ns |
| egr_corr | input | CORR_W | Incoming correction value (ns scaled by 2^16, signed) |
| out_valid | output | 1 | Updated correction strobe |
| out_corr | output | CORR_W | Outgoing correction value |
| out_err | output | 1 | Egress had no matching ingress slot |

## Verification
The bench builds the block with TS_W = 16 and keeps the default TAG_W = 2 and CORR_W = 64. With random 16-bit timestamps, about half of all matched egresses have an egress stamp below the ingress stamp, so the wrap path is used all the time. The four tags are drawn from a small set, which makes hits, misses, re-used tags and same-cycle ingress and egress frequent under random traffic. The full 64-bit correction with random signed values also makes the sum overflow and wrap.

// File: rtl/tc_corr_pkg.sv
package tc_corr_pkg;
  localparam int unsigned TYPE_W = 4;
  localparam logic [TYPE_W-1:0] KIND_SYNC = 4'h0;
  localparam logic [TYPE_W-1:0] KIND_DREQ = 4'h1;

  // Only event messages accumulate residence time
  function automatic logic takes_residence(input logic [TYPE_W-1:0] kind);
    return (kind == KIND_SYNC) || (kind == KIND_DREQ);
  endfunction
endpackage

// File: rtl/tc_stamp_table.sv
module tc_stamp_table #(
  parameter int unsigned TAG_W = 2,
  parameter int unsigned TS_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TS_W-1:0]  wr_ts,
  input  logic             wr_evt,
  input  logic             rd_en,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output logic [TS_W-1:0]  rd_ts,
  output logic             rd_evt
);
  localparam int unsigned DEPTH = 1 << TAG_W;

  logic [DEPTH-1:0] slot_open;
  logic [DEPTH-1:0] slot_evt;
  logic [TS_W-1:0]  slot_ts [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    wire set_here = wr_en && (wr_tag == TAG_W'(i));
    wire clr_here = rd_en && (rd_tag == TAG_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_open[i] <= 1'b0;
        slot_evt[i]  <= 1'b0;
        slot_ts[i]   <= '0;
      end else if (set_here) begin
        slot_open[i] <= 1'b1;
        slot_evt[i]  <= wr_evt;
        slot_ts[i]   <= wr_ts;
      end else if (clr_here) begin
        slot_open[i] <= 1'b0;
      end
    end
  end

  assign rd_hit = slot_open[rd_tag];
  assign rd_ts  = slot_ts[rd_tag];
  assign rd_evt = slot_evt[rd_tag];

  assert_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> slot_open[$past(wr_tag)]);
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !(wr_en && wr_tag == rd_tag)) |=> !slot_open[$past(rd_tag)]);
  assert_keep_new_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en && wr_tag == rd_tag) |=> (slot_ts[$past(wr_tag)] == $past(wr_ts)));
endmodule

// File: rtl/tc_corr_update.sv
module tc_corr_update #(
  parameter int unsigned TS_W      = 32,
  parameter int unsigned CORR_W    = 64,
  parameter int unsigned FRAC_BITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              egr_valid,
  input  logic [TS_W-1:0]   egr_ts,
  input  logic [CORR_W-1:0] corr_in,
  input  logic              hit,
  input  logic [TS_W-1:0]   ing_ts,
  input  logic              evt,
  output logic              out_valid,
  output logic [CORR_W-1:0] out_corr,
  output logic              out_err
);
  // Time in the bridge, wrapping modulo the timestamp width
  function automatic logic [TS_W-1:0] residence(input logic [TS_W-1:0] t_out,
                                                input logic [TS_W-1:0] t_in);
    return t_out - t_in;
  endfunction

  // Residence moved into the scaled correction format
  function automatic logic [CORR_W-1:0] scaled(input logic [TS_W-1:0] r);
    return CORR_W'(r) << FRAC_BITS;
  endfunction

  logic              fire_update;
  logic              fire_miss;
  logic [CORR_W-1:0] next_corr;

  assign fire_update = egr_valid && hit && evt;
  assign fire_miss   = egr_valid && !hit;
  assign next_corr   = fire_update ? corr_in + scaled(residence(egr_ts, ing_ts)) : corr_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_corr  <= '0;
    end else begin
      out_valid <= egr_valid;
      out_err   <= fire_miss;
      if (egr_valid) out_corr <= next_corr;
    end
  end

  assert_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    egr_valid |=> out_valid);
  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !egr_valid |=> !out_valid);
  assert_miss_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire_miss |=> (out_err && out_corr == $past(corr_in)));
  assert_plain_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (egr_valid && hit && !evt) |=> (!out_err && out_corr == $past(corr_in)));
  assert_err_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid);
endmodule

// File: rtl/tc_residence_corr.sv
module tc_residence_corr #(
  parameter int unsigned TAG_W     = 2,
  parameter int unsigned TS_W      = 32,
  parameter int unsigned CORR_W    = 64,
  parameter int unsigned FRAC_BITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ing_valid,
  input  logic [TAG_W-1:0]  ing_tag,
  input  logic [TS_W-1:0]   ing_ts,
  input  logic [3:0]        ing_type,
  input  logic              egr_valid,
  input  logic [TAG_W-1:0]  egr_tag,
  input  logic [TS_W-1:0]   egr_ts,
  input  logic [CORR_W-1:0] egr_corr,
  output logic              out_valid,
  output logic [CORR_W-1:0] out_corr,
  output logic              out_err
);
  logic            ing_is_evt;
  logic            lkp_hit;
  logic [TS_W-1:0] lkp_ts;
  logic            lkp_evt;

  assign ing_is_evt = tc_corr_pkg::takes_residence(ing_type);

  tc_stamp_table #(.TAG_W(TAG_W), .TS_W(TS_W)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ing_valid),
    .wr_tag (ing_tag),
    .wr_ts  (ing_ts),
    .wr_evt (ing_is_evt),
    .rd_en  (egr_valid),
    .rd_tag (egr_tag),
    .rd_hit (lkp_hit),
    .rd_ts  (lkp_ts),
    .rd_evt (lkp_evt)
  );

  tc_corr_update #(.TS_W(TS_W), .CORR_W(CORR_W), .FRAC_BITS(FRAC_BITS)) u_update (
    .clk       (clk),
    .rst_n     (rst_n),
    .egr_valid (egr_valid),
    .egr_ts    (egr_ts),
    .corr_in   (egr_corr),
    .hit       (lkp_hit),
    .ing_ts    (lkp_ts),
    .evt       (lkp_evt),
    .out_valid (out_valid),
    .out_corr  (out_corr),
    .out_err   (out_err)
  );

  assert_reset_R1: assert property (@(posedge clk) !rst_n |=> (!out_valid && !out_err));
endmodule

// File: tb/tc_residence_corr_test.sv
module tc_residence_corr_test;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 2;
  localparam int TS_W = 16;
  localparam int CORR_W = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ing_valid = 1'b0, egr_valid = 1'b0;
  logic [TAG_W-1:0] ing_tag = '0, egr_tag = '0;
  logic [TS_W-1:0] ing_ts = '0, egr_ts = '0;
  logic [3:0] ing_type = '0;
  logic [CORR_W-1:0] egr_corr = '0;
  logic out_valid, out_err;
  logic [CORR_W-1:0] out_corr;

  int checks = 0, errors = 0;
  bit m_open [4];
  bit m_evt [4];
  int m_ts [4];
  int m_kind [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  tc_residence_corr #(.TAG_W(TAG_W), .TS_W(TS_W), .CORR_W(CORR_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .ing_valid(ing_valid), .ing_tag(ing_tag), .ing_ts(ing_ts), .ing_type(ing_type),
    .egr_valid(egr_valid), .egr_tag(egr_tag), .egr_ts(egr_ts), .egr_corr(egr_corr),
    .out_valid(out_valid), .out_corr(out_corr), .out_err(out_err));

  function automatic longint bench_resid(int t_out, int t_in);
    if (t_out >= t_in) return longint'(t_out - t_in);
    return longint'(t_out + 65536 - t_in);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cycle(bit iv, int itag, int its, int ikind,
                       bit ev, int etag, int ets, longint ecorr, string lbl);
    bit exp_e = 1'b0;
    longint exp_c = ecorr;
    string r = lbl;
    ing_valid = iv; ing_tag = TAG_W'(itag); ing_ts = TS_W'(its); ing_type = 4'(ikind);
    egr_valid = ev; egr_tag = TAG_W'(etag); egr_ts = TS_W'(ets); egr_corr = ecorr;
    if (ev) begin
      if (!m_open[etag]) begin
        exp_e = 1'b1;
        if (r == "") r = "R5";
      end else if (m_evt[etag]) begin
        exp_c = ecorr + bench_resid(ets, m_ts[etag]) * 65536;
        if (r == "") r = (ets < m_ts[etag]) ? "R6" : ((m_kind[etag] == 0) ? "R2" : "R3");
      end else if (r == "") r = "R4";
      m_open[etag] = 1'b0;
    end
    if (iv) begin
      m_open[itag] = 1'b1; m_ts[itag] = its; m_kind[itag] = ikind;
      m_evt[itag] = (ikind == 0) || (ikind == 1);
    end
    @(negedge clk);
    chk(out_valid == ev, "R7", "out_valid", longint'(out_valid), longint'(ev));
    if (ev) begin
      chk(out_err == exp_e, r, "out_err", longint'(out_err), longint'(exp_e));
      chk(out_corr == CORR_W'(exp_c), r, "out_corr", longint'(out_corr), exp_c);
    end
  endtask

  task automatic idle();
    cycle(1'b0, 0, 0, 0, 1'b0, 0, 0, 0, "R7");
  endtask

  function automatic int pick_kind();
    case ($urandom % 5)
      0: return 0;
      1: return 1;
      2: return 8;
      3: return 9;
      default: return 3;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", checks, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1588));
    for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_evt[i] = 0; m_ts[i] = 0; m_kind[i] = 0; end
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && out_err == 1'b0, "R1", "reset outputs",
        longint'({out_valid, out_err}), 0);
    rst_n = 1'b1;
    // R1: nothing open after reset
    cycle(1'b0, 0, 0, 0, 1'b1, 2, 100, 64'sd77, "R1");
    idle();
    // R2 / R3 directed
    cycle(1'b1, 0, 1000, 0, 1'b0, 0, 0, 0, "R2");
    cycle(1'b0, 0, 0, 0, 1'b1, 0, 1250, 64'sd5, "R2");
    cycle(1'b1, 1, 2000, 1, 1'b0, 0, 0, 0, "R3");
    cycle(1'b0, 0, 0, 0, 1'b1, 1, 2003, 64'sd9, "R3");
    // R4 follow-up and delay response pass unchanged
    cycle(1'b1, 2, 300, 8, 1'b0, 0, 0, 0, "R4");
    cycle(1'b0, 0, 0, 0, 1'b1, 2, 900, 64'sd1234, "R4");
    cycle(1'b1, 3, 300, 9, 1'b0, 0, 0, 0, "R4");
    cycle(1'b0, 0, 0, 0, 1'b1, 3, 900, -64'sd44, "R4");
    // R6 wrap
    cycle(1'b1, 0, 65530, 0, 1'b0, 0, 0, 0, "R6");
    cycle(1'b0, 0, 0, 0, 1'b1, 0, 10, 64'sd0, "R6");
    // R8 second egress on a released tag
    cycle(1'b0, 0, 0, 0, 1'b1, 0, 20, 64'sd3, "R8");
    // R9 same-cycle ingress and egress on one tag
    cycle(1'b1, 2, 100, 0, 1'b0, 0, 0, 0, "R9");
    cycle(1'b1, 2, 500, 1, 1'b1, 2, 400, 64'sd0, "R9");
    cycle(1'b0, 0, 0, 0, 1'b1, 2, 560, 64'sd0, "R9");
    // R10 four in flight, out of order
    for (int t = 0; t < 4; t++) cycle(1'b1, t, 100 * (t + 1), t % 2, 1'b0, 0, 0, 0, "R10");
    cycle(1'b0, 0, 0, 0, 1'b1, 3, 1000, 64'sd1, "R10");
    cycle(1'b0, 0, 0, 0, 1'b1, 1, 1000, 64'sd2, "R10");
    cycle(1'b0, 0, 0, 0, 1'b1, 0, 1000, 64'sd3, "R10");
    cycle(1'b0, 0, 0, 0, 1'b1, 2, 1000, 64'sd4, "R10");
    // R11 negative correction and 64-bit wrap
    cycle(1'b1, 1, 50, 0, 1'b0, 0, 0, 0, "R11");
    cycle(1'b0, 0, 0, 0, 1'b1, 1, 60, -64'sd900000, "R11");
    cycle(1'b1, 1, 50, 1, 1'b0, 0, 0, 0, "R11");
    cycle(1'b0, 0, 0, 0, 1'b1, 1, 40000, 64'h7FFF_FFFF_FFFF_FFF0, "R11");
    idle();
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      cycle(($urandom % 2) == 1, $urandom % 4, $urandom % 65536, pick_kind(),
            ($urandom % 2) == 1, $urandom % 4, $urandom % 65536,
            longint'({$urandom, $urandom}), "");
    end
    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule